// File: doc/BRIEF.md
# Two-Word Floating Divide Sequencer

This block divides a two-word floating-point dividend by a two-word floating-point divisor. The result is a normalized two-word quotient. Each 36-bit word is laid out as sign in bit 35, an excess-128 characteristic in bits 34:27, and a 27-bit fraction in bits 26:0. The fraction of the low word continues the fraction of the high word. The datapath has one 27-bit fraction divider and one 28-by-27 multiplier. The full 54-bit quotient comes from two passes through that single divider, not from one wide divide.

Call the dividend fractions A (high) and B (low), and the divisor fractions C (high) and D (low). The first pass divides the 54-bit value A:B by C, giving a 28-bit quotient Q1 and a remainder R1. The block then forms P, the upper part of Q1·D, with the 27 least significant product bits dropped. The correction W = R1 − P is a signed value. The second pass divides |W|·2^27 by C, giving Q2. The mantissa is Q1·2^27 + Q2 when W is positive and Q1·2^27 − Q2 when W is negative. It is normalized with truncation.

A divide check stops either pass when the working fraction is at least twice C. A halt-mode input selects the response: the block either freezes after a check or only reports it. The divisor is assumed normalized (C bit 26 set) unless it triggers the divide check.

Top module: `fdiv_dp_seq`

## Requirements
- R1: On success the 54-bit result fraction (res_hi[26:0]:res_lo[26:0]) equals M, the mantissa Q1·2^27 ± Q2. M is shifted so that its leading one lands in bit 53, with bits shifted out on the right discarded. It is exactly Q1, R1, P, W and Q2 as defined above that build M.
- R2: On success with nonzero M, the high characteristic is charA − charC + 128 + s, where s is the normalization shift (leading-one position minus 53). The low characteristic is the high characteristic minus 27. Both are truncated to 8 bits.
- R3: On success both result words carry the sign signA XOR signC.
- R4: If A and B are both zero, both result words have zero characteristic and zero fraction, and both carry signA XOR signC. A successful quotient with M = 0 gives the same words.
- R5: If the dividend is nonzero and A ≥ 2·C, div_check is set. Both result words keep the original dividend characteristics and fractions, and both take signA.
- R6: If |W| ≥ 2·C before the second pass, div_check is set. Both words become signA with zero characteristic and zero fraction.
- R7: char_ovf is set when the high characteristic before truncation exceeds 255. char_unf is set when the low characteristic before truncation is below 0. Both flags are clear whenever div_check is set or the result is zero.
- R8: With halt_mode high at start, a divide check leaves the block halted: halted and busy stay high and start is ignored until reset. With halt_mode low, the block returns to idle.
- R9: done is a single-cycle pulse that marks the cycle in which the results and flags become valid. busy is high from the cycle after an accepted start until that done cycle.
- R10: start is ignored while busy. An operation runs on the operands captured when it started.
- R11: After reset, busy, done, halted, div_check, char_ovf, char_unf, res_hi and res_lo are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request, accepted only when idle |
| halt_mode | input | 1 | 1: freeze on divide check; 0: report and continue |
| dvd_hi | input | 36 | Dividend high word |
| dvd_lo | input | 36 | Dividend low word |
| dvs_hi | input | 36 | Divisor high word |
| dvs_lo | input | 36 | Divisor low word (fraction only is used) |
| busy | output | 1 | Operation in progress, or halted |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Frozen after a divide check in halt mode |
| div_check | output | 1 | Divide check occurred in the last operation |
| char_ovf | output | 1 | Characteristic overflow of the last operation |
| char_unf | output | 1 | Characteristic underflow of the last operation |
| res_hi | output | 36 | Quotient high word |
| res_lo | output | 36 | Quotient low word |

## Verification
Some properties are checked on every cycle. These cover the remainder invariant of the shared divider, the single-cycle done pulse, and halt being sticky. They also cover equal signs on both result words, a set leading bit in a normalized nonzero result, the 27-step gap between the two characteristics, and clear overflow and underflow flags whenever a divide check is reported. The actual quotient values are shown only by the bench scenarios. So are the choice between the zero, first-check and second-check outcomes, the overflow and underflow boundaries, and the rule that a start during an operation is ignored. The bench compares these against an arithmetic model of the two-pass algorithm.

// File: rtl/fdiv_pkg.sv
// Shared widths and types for the two-word floating divide sequencer.
// Assumes a 36-bit word: sign, 8-bit excess-128 characteristic, 27-bit fraction.
package fdiv_pkg;
    localparam int FRAC_W    = 27;
    localparam int CHAR_W    = 8;
    localparam int WORD_W    = 1 + CHAR_W + FRAC_W;
    localparam int QUO_W     = FRAC_W + 1;
    localparam int EXP_W     = CHAR_W + 3;
    localparam int NORM_W    = 2 * FRAC_W;
    localparam int MANT_W    = 2 * FRAC_W + 2;
    localparam int CHAR_BIAS = 128;

    typedef struct packed {
        logic              sgn;
        logic [CHAR_W-1:0] chr;
        logic [FRAC_W-1:0] frac;
    } fword_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHK1, ST_DIV1, ST_CHK2, ST_DIV2, ST_FIN, ST_HALT
    } seq_st_t;
endpackage

// File: rtl/fdiv_restoring.sv
// Sequential restoring divider of a (W+1)+W bit numerator by a W-bit divisor.
// Produces a W+1 bit quotient in W+1 cycles after go; fin pulses for one cycle.
// Assumes num_hi < 2*dvs and that dvs stays stable while running.
module fdiv_restoring #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W:0]   num_hi,
    input  logic [W-1:0] num_lo,
    input  logic [W-1:0] dvs,
    output logic [W:0]   quo,
    output logic [W-1:0] rem,
    output logic         fin
);
    localparam int CNT_W = $clog2(W + 2);

    logic [W:0]     r;
    logic [W:0]     lo_sh;
    logic [W:0]     q;
    logic [CNT_W-1:0] cnt;
    logic           run;
    logic [W+1:0]   trial;
    logic           fits;

    // Next partial remainder candidate: shift in the next numerator bit.
    assign trial = {r, lo_sh[W]};
    assign fits  = trial >= {2'b00, dvs};

    // One quotient bit per cycle; load on go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r <= '0; lo_sh <= '0; q <= '0; cnt <= '0; run <= 1'b0; fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                r     <= {1'b0, num_hi[W:1]};
                lo_sh <= {num_hi[0], num_lo};
                q     <= '0;
                cnt   <= CNT_W'(W + 1);
                run   <= 1'b1;
            end else if (run) begin
                r     <= fits ? (W+1)'(trial - {2'b00, dvs}) : trial[W:0];
                lo_sh <= lo_sh << 1;
                q     <= {q[W-1:0], fits};
                cnt   <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign quo = q;
    assign rem = W'(r);

    // R1: the partial remainder never reaches the divisor while iterating
    p_partial_below_divisor_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (r < {1'b0, dvs}));
endmodule

// File: rtl/fdiv_correct.sv
// Correction step between the two passes: P = upper part of Q1*D,
// W = R1 - P as sign and magnitude, and the second divide check |W| >= 2C.
// Purely combinational; assumes inputs are held stable by the sequencer.
module fdiv_correct import fdiv_pkg::*; #(
    parameter int FW = FRAC_W
) (
    input  logic [FW:0]   q1,
    input  logic [FW-1:0] r1,
    input  logic [FW-1:0] d,
    input  logic [FW-1:0] c,
    output logic [FW:0]   wmag,
    output logic          wneg,
    output logic          too_big
);
    localparam int PROD_W = 2 * FW + 1;

    logic [FW:0]   p;
    logic [FW+1:0] w;

    // Keep only the high half of the product; the low FW bits are dropped.
    assign p       = (FW+1)'((PROD_W'(q1) * PROD_W'(d)) >> FW);
    assign w       = {2'b00, r1} - {1'b0, p};
    assign wneg    = w[FW+1];
    assign wmag    = wneg ? (FW+1)'(-w) : w[FW:0];
    assign too_big = wmag >= {c, 1'b0};
endmodule

// File: rtl/fdiv_norm.sv
// Forms the mantissa Q1*2^FW +/- Q2, finds its leading one and normalizes
// it to a 2*FW bit fraction with truncation; returns the adjusted exponent.
module fdiv_norm import fdiv_pkg::*; #(
    parameter int FW = FRAC_W,
    parameter int EW = EXP_W
) (
    input  logic [FW:0]          q1,
    input  logic [FW:0]          q2,
    input  logic                 q2neg,
    input  logic signed [EW-1:0] base,
    output logic [2*FW-1:0]      frac,
    output logic signed [EW-1:0] expo,
    output logic                 zero
);
    localparam int MW     = 2 * FW + 2;
    localparam int NW     = 2 * FW;
    localparam int LEAD_W = $clog2(MW);

    logic [MW-1:0]     m;
    logic [MW-1:0]     top_part;
    logic [LEAD_W-1:0] lead;

    assign top_part = {1'b0, q1, FW'(0)};
    assign m        = q2neg ? top_part - MW'(q2) : top_part + MW'(q2);
    assign zero     = (m == '0);

    // Priority search for the most significant set bit.
    always_comb begin
        lead = '0;
        for (int i = 0; i < MW; i++) begin
            if (m[i]) lead = i[LEAD_W-1:0];
        end
    end

    // Align the leading one to the top fraction bit.
    always_comb begin
        if (lead >= LEAD_W'(NW - 1)) frac = NW'(m >> (lead - LEAD_W'(NW - 1)));
        else                         frac = NW'(m << (LEAD_W'(NW - 1) - lead));
    end

    assign expo = base + EW'(lead) - EW'(NW - 1);
endmodule

// File: rtl/fdiv_dp_seq.sv
// Two-word floating divide sequencer. Captures operands on start, runs two
// passes through one fraction divider with a multiply correction in between,
// normalizes Q1 +/- Q2, and applies the zero, divide-check and flag rules.
// Assumes a normalized divisor fraction unless it triggers the divide check.
module fdiv_dp_seq import fdiv_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              halt_mode,
    input  logic [WORD_W-1:0] dvd_hi,
    input  logic [WORD_W-1:0] dvd_lo,
    input  logic [WORD_W-1:0] dvs_hi,
    input  logic [WORD_W-1:0] dvs_lo,
    output logic              busy,
    output logic              done,
    output logic              halted,
    output logic              div_check,
    output logic              char_ovf,
    output logic              char_unf,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo
);
    seq_st_t           st;
    fword_t            a_q, b_q, c_q;
    logic [FRAC_W-1:0] d_q;
    logic              hm_q;
    logic [QUO_W-1:0]  q1_q, q2_q;
    logic [FRAC_W-1:0] r1_q;

    logic              dv_go, dv_fin;
    logic [QUO_W-1:0]  dv_hi, dv_quo, wmag;
    logic [FRAC_W-1:0] dv_lo, dv_rem;
    logic              wneg, chk2;
    logic [NORM_W-1:0] nfrac;
    logic signed [EXP_W-1:0] nexp, base_exp;
    logic              nzero;
    logic              dvd_zero, chk1, q_sign;
    logic [CHAR_W-1:0] chr_lo;
    logic              unused_dvs_lo;

    assign unused_dvs_lo = ^dvs_lo[WORD_W-1:FRAC_W];

    // Operand tests that pick the outcome before each pass.
    assign dvd_zero = (a_q.frac == '0) && (b_q.frac == '0);
    assign chk1     = {1'b0, a_q.frac} >= {c_q.frac, 1'b0};
    assign q_sign   = a_q.sgn ^ c_q.sgn;
    assign base_exp = EXP_W'(a_q.chr) - EXP_W'(c_q.chr) + EXP_W'(CHAR_BIAS);
    assign chr_lo   = nexp[CHAR_W-1:0] - CHAR_W'(FRAC_W);

    // Divider launch and operand selection for the two passes.
    assign dv_go = ((st == ST_CHK1) && !dvd_zero && !chk1) || ((st == ST_CHK2) && !chk2);
    assign dv_hi = (st == ST_CHK1) ? {1'b0, a_q.frac} : wmag;
    assign dv_lo = (st == ST_CHK1) ? b_q.frac : '0;

    fdiv_restoring #(.W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dv_go), .num_hi(dv_hi), .num_lo(dv_lo),
        .dvs(c_q.frac), .quo(dv_quo), .rem(dv_rem), .fin(dv_fin)
    );

    fdiv_correct #(.FW(FRAC_W)) u_corr (
        .q1(q1_q), .r1(r1_q), .d(d_q), .c(c_q.frac),
        .wmag(wmag), .wneg(wneg), .too_big(chk2)
    );

    fdiv_norm #(.FW(FRAC_W), .EW(EXP_W)) u_norm (
        .q1(q1_q), .q2(q2_q), .q2neg(wneg), .base(base_exp),
        .frac(nfrac), .expo(nexp), .zero(nzero)
    );

    // Sequencer: capture, two passes, result formation and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; a_q <= '0; b_q <= '0; c_q <= '0; d_q <= '0; hm_q <= 1'b0;
            q1_q <= '0; q2_q <= '0; r1_q <= '0; done <= 1'b0; div_check <= 1'b0;
            char_ovf <= 1'b0; char_unf <= 1'b0; res_hi <= '0; res_lo <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    a_q  <= fword_t'(dvd_hi);
                    b_q  <= fword_t'(dvd_lo);
                    c_q  <= fword_t'(dvs_hi);
                    d_q  <= dvs_lo[FRAC_W-1:0];
                    hm_q <= halt_mode;
                    st   <= ST_CHK1;
                end
                ST_CHK1: if (dvd_zero) begin
                    res_hi    <= {q_sign, CHAR_W'(0), FRAC_W'(0)};
                    res_lo    <= {q_sign, CHAR_W'(0), FRAC_W'(0)};
                    div_check <= chk1;
                    char_ovf  <= 1'b0;
                    char_unf  <= 1'b0;
                    done      <= 1'b1;
                    st        <= (chk1 && hm_q) ? ST_HALT : ST_IDLE;
                end else if (chk1) begin
                    res_hi    <= {a_q.sgn, a_q.chr, a_q.frac};
                    res_lo    <= {a_q.sgn, b_q.chr, b_q.frac};
                    div_check <= 1'b1;
                    char_ovf  <= 1'b0;
                    char_unf  <= 1'b0;
                    done      <= 1'b1;
                    st        <= hm_q ? ST_HALT : ST_IDLE;
                end else begin
                    st <= ST_DIV1;
                end
                ST_DIV1: if (dv_fin) begin
                    q1_q <= dv_quo;
                    r1_q <= dv_rem;
                    st   <= ST_CHK2;
                end
                ST_CHK2: if (chk2) begin
                    res_hi    <= {a_q.sgn, CHAR_W'(0), FRAC_W'(0)};
                    res_lo    <= {a_q.sgn, CHAR_W'(0), FRAC_W'(0)};
                    div_check <= 1'b1;
                    char_ovf  <= 1'b0;
                    char_unf  <= 1'b0;
                    done      <= 1'b1;
                    st        <= hm_q ? ST_HALT : ST_IDLE;
                end else begin
                    st <= ST_DIV2;
                end
                ST_DIV2: if (dv_fin) begin
                    q2_q <= dv_quo;
                    st   <= ST_FIN;
                end
                ST_FIN: begin
                    div_check <= 1'b0;
                    done      <= 1'b1;
                    st        <= ST_IDLE;
                    if (nzero) begin
                        res_hi   <= {q_sign, CHAR_W'(0), FRAC_W'(0)};
                        res_lo   <= {q_sign, CHAR_W'(0), FRAC_W'(0)};
                        char_ovf <= 1'b0;
                        char_unf <= 1'b0;
                    end else begin
                        res_hi   <= {q_sign, nexp[CHAR_W-1:0], nfrac[NORM_W-1:FRAC_W]};
                        res_lo   <= {q_sign, chr_lo, nfrac[FRAC_W-1:0]};
                        char_ovf <= nexp > $signed(EXP_W'(255));
                        char_unf <= nexp < $signed(EXP_W'(FRAC_W));
                    end
                end
                ST_HALT: st <= ST_HALT;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st != ST_IDLE);
    assign halted = (st == ST_HALT);

    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a halted block stays halted and busy until reset
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && busy));
    // R7: a divide check clears both characteristic flags
    p_check_clears_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_check) |-> (!char_ovf && !char_unf));
    // R3: both result words always leave with the same sign
    p_same_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_hi[WORD_W-1] == res_lo[WORD_W-1]));
    // R1: a successful nonzero result has its top fraction bit set
    p_norm_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_check && (res_hi[FRAC_W-1:0] != '0)) |-> res_hi[FRAC_W-1]);
    // R2: low characteristic trails the high one by the fraction width
    p_char_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_check && (res_hi[FRAC_W-1:0] != '0))
        |-> (res_lo[WORD_W-2:FRAC_W] == res_hi[WORD_W-2:FRAC_W] - CHAR_W'(FRAC_W)));
endmodule

// File: tb/tb_fdiv_dp_seq.sv
`timescale 1ns/1ps
module tb_fdiv_dp_seq;
    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, halt_mode = 1'b0;
    logic [35:0] dvd_hi = '0, dvd_lo = '0, dvs_hi = '0, dvs_lo = '0;
    logic        busy, done, halted, div_check, char_ovf, char_unf;
    logic [35:0] res_hi, res_lo;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    fdiv_dp_seq dut (.*);

    task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] mk(input logic s, input int ch, input logic [26:0] fr);
        return {s, ch[7:0], fr};
    endfunction

    // Arithmetic model of the two-pass divide from the requirements.
    task automatic model(input logic [35:0] ah, al, ch, cl,
                         output logic [35:0] eh, el, output logic edc, eov, eun);
        longint unsigned a, b, c, d, n, q1, r1, p, mag, q2, m, f;
        longint w;
        int lead, e, elo;
        logic sa, sg;
        a = ah[26:0]; b = al[26:0]; c = ch[26:0]; d = cl[26:0];
        sa = ah[35]; sg = ah[35] ^ ch[35];
        eov = 0; eun = 0; edc = 0;
        if (a == 0 && b == 0) begin
            eh = {sg, 35'd0}; el = {sg, 35'd0}; edc = (a >= 2 * c);
        end else if (a >= 2 * c) begin
            eh = {sa, ah[34:0]}; el = {sa, al[34:0]}; edc = 1;
        end else begin
            n = (a << 27) | b; q1 = n / c; r1 = n % c; p = (q1 * d) >> 27;
            w = longint'(r1) - longint'(p);
            mag = (w < 0) ? longint'(-w) : longint'(w);
            if (mag >= 2 * c) begin
                eh = {sa, 35'd0}; el = {sa, 35'd0}; edc = 1;
            end else begin
                q2 = (mag << 27) / c;
                m = (w < 0) ? (q1 << 27) - q2 : (q1 << 27) + q2;
                if (m == 0) begin
                    eh = {sg, 35'd0}; el = {sg, 35'd0};
                end else begin
                    lead = 0;
                    for (int i = 0; i < 56; i++) if (m[i]) lead = i;
                    f = (lead >= 53) ? (m >> (lead - 53)) : (m << (53 - lead));
                    e = int'(ah[34:27]) - int'(ch[34:27]) + 128 + lead - 53;
                    elo = e - 27;
                    eh = {sg, e[7:0], f[53:27]};
                    el = {sg, elo[7:0], f[26:0]};
                    eov = (e > 255); eun = (elo < 0);
                end
            end
        end
    endtask

    // Pulses start and waits for done; returns 1 if done arrived.
    task automatic launch(input logic [35:0] ah, al, ch, cl, input logic hm, output bit got);
        @(negedge clk);
        dvd_hi = ah; dvd_lo = al; dvs_hi = ch; dvs_lo = cl; halt_mode = hm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", 72'(busy), 72'd1);
        got = 0;
        for (int k = 0; k < 300; k++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        if (!got) chk(1'b0, "R9 done timeout", 72'd0, 72'd1);
    endtask

    task automatic check_op(input string req, input logic [35:0] ah, al, ch, cl);
        logic [35:0] eh, el; logic edc, eov, eun; bit got;
        model(ah, al, ch, cl, eh, el, edc, eov, eun);
        launch(ah, al, ch, cl, 1'b0, got);
        if (got) begin
            chk({res_hi, res_lo} == {eh, el}, req, {res_hi, res_lo}, {eh, el});
            chk({div_check, char_ovf, char_unf} == {edc, eov, eun}, {req, " flags"},
                72'({div_check, char_ovf, char_unf}), 72'({edc, eov, eun}));
            chk(busy == 1'b0, "R8 proceed returns idle", 72'(busy), 72'd0);
            @(negedge clk);
            chk(done == 1'b0, "R9 done one cycle", 72'(done), 72'd0);
        end
    endtask

    task automatic t_reset();
        chk({busy, done, halted, div_check, char_ovf, char_unf} == 6'b0, "R11 reset flags",
            72'({busy, done, halted, div_check, char_ovf, char_unf}), 72'd0);
        chk({res_hi, res_lo} == 72'd0, "R11 reset words", {res_hi, res_lo}, 72'd0);
    endtask

    task automatic t_quotients();
        check_op("R1 R2 one over one", mk(0,128,27'h4000000), mk(0,101,0), mk(0,128,27'h4000000), mk(0,101,0));
        check_op("R1 R2 mixed", mk(0,130,27'h6000000), mk(0,103,27'h1234567), mk(0,127,27'h5555555), mk(0,100,27'h2AAAAAA));
        check_op("R1 near twice", mk(0,129,27'h7FFFFFF), mk(0,102,27'h7FFFFFF), mk(0,128,27'h4000001), mk(0,101,27'h0000FFF));
        check_op("R1 small dividend", mk(0,128,27'h0000100), mk(0,101,27'h5), mk(0,128,27'h7000000), mk(0,101,27'h7FFFFFF));
    endtask

    task automatic t_signs();
        check_op("R3 unlike signs", mk(1,130,27'h6000000), mk(1,103,27'h1234567), mk(0,127,27'h5555555), mk(0,100,27'h2AAAAAA));
        check_op("R3 both negative", mk(1,130,27'h6000000), mk(1,103,27'h1234567), mk(1,127,27'h5555555), mk(1,100,27'h2AAAAAA));
    endtask

    task automatic t_zero();
        check_op("R4 zero alike", mk(0,77,0), mk(0,50,0), mk(0,128,27'h5000000), mk(0,101,27'h3));
        chk(res_hi == 36'd0, "R4 zero word plus", 72'(res_hi), 72'd0);
        check_op("R4 zero unlike", mk(0,77,0), mk(0,50,0), mk(1,128,27'h5000000), mk(1,101,27'h3));
        chk(res_lo == {1'b1, 35'd0}, "R4 zero word minus", 72'(res_lo), 72'({1'b1, 35'd0}));
    endtask

    task automatic t_check1();
        check_op("R5 first check", mk(1,140,27'h7000000), mk(0,113,27'h0ABCDEF), mk(0,120,27'h3000000), mk(0,93,27'h1));
        chk(div_check == 1'b1 && res_lo == mk(1,113,27'h0ABCDEF), "R5 words kept with dividend sign",
            72'(res_lo), 72'(mk(1,113,27'h0ABCDEF)));
    endtask

    task automatic t_check2();
        check_op("R6 second check", mk(0,140,27'h7FFFFFF), mk(0,113,0), mk(1,130,27'h4000000), mk(1,103,27'h7FFFFFF));
        chk(div_check == 1'b1 && res_hi == 36'd0, "R6 cleared words", 72'(res_hi), 72'd0);
    endtask

    task automatic t_flags();
        check_op("R7 overflow", mk(0,255,27'h6000000), mk(0,228,27'h1234567), mk(0,0,27'h5555555), mk(0,0,27'h2AAAAAA));
        check_op("R7 underflow high", mk(0,3,27'h6000000), mk(0,0,27'h1234567), mk(0,200,27'h5555555), mk(0,173,27'h2AAAAAA));
        check_op("R7 underflow low only", mk(0,10,27'h6000000), mk(0,0,27'h1234567), mk(0,120,27'h5555555), mk(0,93,27'h2AAAAAA));
    endtask

    task automatic t_busy_ignore();
        logic [35:0] eh, el; logic edc, eov, eun; bit got;
        model(mk(0,130,27'h6000000), mk(0,103,27'h1234567), mk(0,127,27'h5555555), mk(0,100,27'h2AAAAAA), eh, el, edc, eov, eun);
        @(negedge clk);
        dvd_hi = mk(0,130,27'h6000000); dvd_lo = mk(0,103,27'h1234567);
        dvs_hi = mk(0,127,27'h5555555); dvs_lo = mk(0,100,27'h2AAAAAA); halt_mode = 0; start = 1;
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        dvd_hi = mk(1,20,27'h4000000); dvs_hi = mk(0,200,27'h7000000); start = 1;
        @(negedge clk); start = 0;
        got = 0;
        for (int k = 0; k < 300; k++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got && {res_hi, res_lo} == {eh, el}, "R10 start ignored while busy", {res_hi, res_lo}, {eh, el});
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10 no second operation", 72'(busy), 72'd0);
    endtask

    task automatic t_halt();
        bit got; bit seen;
        launch(mk(0,140,27'h7000000), mk(0,113,0), mk(0,120,27'h3000000), mk(0,93,0), 1'b1, got);
        chk(got && div_check, "R8 halt run flags check", 72'(div_check), 72'd1);
        @(negedge clk);
        chk(halted && busy, "R8 halted and busy", 72'({halted, busy}), 72'd3);
        start = 1; dvd_hi = mk(0,128,27'h4000000); dvs_hi = mk(0,128,27'h4000000);
        @(negedge clk); start = 0;
        seen = 0;
        for (int k = 0; k < 60; k++) begin
            if (done) seen = 1;
            @(negedge clk);
        end
        chk(!seen && halted, "R8 start ignored when halted", 72'({seen, halted}), 72'd1);
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        t_reset();
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog expired", 72'd0, 72'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_quotients();
        t_signs();
        t_zero();
        t_check1();
        t_check2();
        t_flags();
        t_busy_ignore();
        t_halt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule